// File: doc/BRIEF.md
# SPI memory-card command engine (host side)

This block is the host end of a card link running in SPI mode. A one-cycle start request hands it a six-byte command frame, a flag that picks a one- or two-byte reply, and a flag that marks the command as one whose reply is followed by a busy period. The engine lowers chip select and shifts the frame out most significant bit first on a serial clock derived from the system clock. It then polls the card with all-ones bytes until a reply byte with its top bit clear arrives, and captures that byte and, if asked, the byte after it.

For busy-type commands the engine keeps polling until the card lets its data line go high for a whole byte. A build-time option makes it drop chip select for one byte slot between busy polls, with the clock still running, and re-select the card before the next poll. Every transaction ends with a fixed number of idle byte slots under chip select, so the card gets its trailing clocks. Then chip select rises, the clock stops, and a one-cycle done pulse reports success, reply timeout or busy timeout, together with the captured reply.

Top module: `spi_card_cmd_host`

## Requirements
- R1: A start pulse while idle latches the command, lowers cs_n and sends the six bytes of cmd_i on mosi, cmd_i[47:40] first and each byte MSB first, over the first 48 sclk rising edges. A start pulse during a transaction is ignored.
- R2: sclk idles low and toggles every HALF_DIV system clocks while active (mode 0). mosi changes only on a falling sclk edge or when a transaction begins, and cs_n changes only while sclk is low.
- R3: After the command, each received byte is a poll. The first poll byte with bit 7 equal to 0 becomes resp_o[7:0]. If RESP_WAIT polls pass without one, resp_tmo_o is reported and resp_o is 16'h0000.
- R4: With resp_two_i set at start, the byte after the first reply byte is captured into resp_o[15:8]. Otherwise resp_o[15:8] is 8'h00.
- R5: With busy_type_i set at start, polling continues after the reply until a byte reads 8'hFF. Without it, miso after the reply has no effect on timing or status.
- R6: If BUSY_MAX busy polls in a row read a value other than 8'hFF, busy_tmo_o is reported. Only a busy-type transaction can report it.
- R7: With RELEASE_CS=1, every busy poll that is not 8'hFF is followed by exactly one byte slot with cs_n high and sclk running. Data sampled in that slot is ignored, and cs_n falls again before the next poll.
- R8: After the reply, the busy end or a timeout, the engine clocks TRAIL_BYTES further bytes with cs_n low. Then cs_n rises and sclk stops low.
- R9: mosi is 1 during every bit period that is not part of the command frame, including polls, deselected slots, trailing slots and idle.
- R10: done_o is high for exactly one cycle per transaction. Exactly one of ok_o, resp_tmo_o and busy_tmo_o is high with it, and these and resp_o hold until the next start.
- R11: Out of reset, cs_n_o=1, sclk_o=0, mosi_o=1, busy_o=0 and done_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| cmd_i | input | 48 | Command frame, first byte in the top bits |
| resp_two_i | input | 1 | 1: two-byte reply expected |
| busy_type_i | input | 1 | 1: reply is followed by a busy period |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ok_o | output | 1 | Completed without timeout |
| resp_tmo_o | output | 1 | No reply byte within RESP_WAIT polls |
| busy_tmo_o | output | 1 | Busy outlasted BUSY_MAX polls |
| resp_o | output | 16 | First reply byte in [7:0], second in [15:8] |
| sclk_o | output | 1 | Serial clock to the card |
| mosi_o | output | 1 | Serial data to the card |
| cs_n_o | output | 1 | Active-low card select |
| miso_i | input | 1 | Serial data from the card |

## Verification
Embedded properties check on every cycle the idle pin levels, that mosi stays high while the card is deselected, that cs_n only moves with sclk low and is high mid-transaction only around busy polling, that done lasts one cycle with exactly one status bit, and that a reply timeout leaves the reply empty. Only the bench's card model can show the things that depend on a whole exchange. These are the exact command bits the card receives, and the number of clock edges each transaction spends, which covers the reply gap, the two-byte capture, the busy end and the trailing slots. They also include the number of edges spent deselected, and that busy data on miso has no effect on a non-busy command. The bench sweeps the reply gap through and past the poll limit and the busy length through and past the poll limit. It drives two instances at once, one with chip-select release between busy polls and one without.

// File: rtl/spi_cmd_host_pkg.sv
package spi_cmd_host_pkg;
    localparam int BYTE_W = 8;
    localparam int RESP_W = 16;
    localparam logic [BYTE_W-1:0] IDLE_BYTE = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_WAIT,
        ST_RESP2,
        ST_BUSY,
        ST_DESEL,
        ST_TRAIL,
        ST_END
    } host_st_e;
endpackage

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic sclk_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int DIVW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    typedef struct packed {
        logic [DIVW-1:0] div;
        logic            sclk;
    } gen_t;

    gen_t q, d;
    logic tick;

    assign tick = run_i && (q.div == DIVW'(HALF_DIV - 1));

    always_comb begin
        d = q;
        if (!run_i) begin
            d = '0;
        end else if (tick) begin
            d.div  = '0;
            d.sclk = ~q.sclk;
        end else begin
            d.div = q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sclk_o = q.sclk;
    assign rise_o = tick && !q.sclk;
    assign fall_o = tick && q.sclk;

    // sclk never toggles while the generator is halted
    a_r2_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> $stable(sclk_o) || !sclk_o);
endmodule

// File: rtl/spi_byte_shift.sv
module spi_byte_shift
    import spi_cmd_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] load_byte_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic [BYTE_W-1:0] next_byte_i,
    input  logic              miso_i,
    output logic              mosi_o,
    output logic              byte_done_o,
    output logic [BYTE_W-1:0] rx_byte_o,
    output logic              boundary_o
);
    localparam int BITW = $clog2(BYTE_W);

    typedef struct packed {
        logic [BYTE_W-1:0] tx;
        logic [BYTE_W-1:0] rx;
        logic [BITW-1:0]   bcnt;
        logic              mosi;
        logic              bnd;
    } sh_t;

    sh_t q, d;

    always_comb begin
        d = q;
        if (load_i) begin
            d.tx   = {load_byte_i[BYTE_W-2:0], 1'b1};
            d.mosi = load_byte_i[BYTE_W-1];
            d.bcnt = '0;
            d.bnd  = 1'b0;
        end else begin
            if (rise_i) begin
                d.rx   = {q.rx[BYTE_W-2:0], miso_i};
                d.bcnt = q.bcnt + 1'b1;
                if (q.bcnt == BITW'(BYTE_W - 1)) begin
                    d.tx  = next_byte_i;
                    d.bnd = 1'b1;
                end
            end
            if (fall_i) begin
                d.mosi = q.tx[BYTE_W-1];
                d.tx   = {q.tx[BYTE_W-2:0], 1'b1};
                d.bnd  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.tx   <= IDLE_BYTE;
            q.mosi <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign mosi_o      = q.mosi;
    assign byte_done_o = rise_i && (q.bcnt == BITW'(BYTE_W - 1));
    assign rx_byte_o   = {q.rx[BYTE_W-2:0], miso_i};
    assign boundary_o  = fall_i && q.bnd;

    // R2: serial output moves only at a falling edge or a fresh load
    a_r2_mosi_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mosi_o) |-> $past(fall_i) || $past(load_i));
endmodule

// File: rtl/spi_card_cmd_host.sv
module spi_card_cmd_host
    import spi_cmd_host_pkg::*;
#(
    parameter int HALF_DIV    = 2,
    parameter int CMD_BYTES   = 6,
    parameter int RESP_WAIT   = 8,
    parameter int BUSY_MAX    = 64,
    parameter int TRAIL_BYTES = 1,
    parameter int RELEASE_CS  = 0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic [CMD_BYTES*BYTE_W-1:0] cmd_i,
    input  logic                        resp_two_i,
    input  logic                        busy_type_i,
    output logic                        busy_o,
    output logic                        done_o,
    output logic                        ok_o,
    output logic                        resp_tmo_o,
    output logic                        busy_tmo_o,
    output logic [RESP_W-1:0]           resp_o,
    output logic                        sclk_o,
    output logic                        mosi_o,
    output logic                        cs_n_o,
    input  logic                        miso_i
);
    localparam int CMD_W  = CMD_BYTES * BYTE_W;
    localparam int IDXW   = (CMD_BYTES > 1) ? $clog2(CMD_BYTES) : 1;
    localparam int MAXC_A = (RESP_WAIT > BUSY_MAX) ? RESP_WAIT : BUSY_MAX;
    localparam int MAXC   = (MAXC_A > TRAIL_BYTES) ? MAXC_A : TRAIL_BYTES;
    localparam int CNTW   = $clog2(MAXC + 1);

    typedef struct packed {
        host_st_e          st;
        logic [IDXW-1:0]   idx;
        logic [CNTW-1:0]   cnt;
        logic [CMD_W-1:0]  cmd;
        logic              two;
        logic              btype;
        logic              cs_n;
        logic              cs_pend;
        logic              run;
        logic              done;
        logic              ok;
        logic              rto;
        logic              bto;
        logic [RESP_W-1:0] resp;
    } ctl_t;

    ctl_t q, d;

    logic              rise, fall, byte_done, boundary, load;
    logic [BYTE_W-1:0] rx_byte, next_byte;
    logic [CMD_W-1:0]  cmd_shift;

    spi_sclk_gen #(.HALF_DIV(HALF_DIV)) u_gen (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (q.run),
        .sclk_o (sclk_o),
        .rise_o (rise),
        .fall_o (fall)
    );

    spi_byte_shift u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .load_byte_i (cmd_i[CMD_W-1 -: BYTE_W]),
        .rise_i      (rise),
        .fall_i      (fall),
        .next_byte_i (next_byte),
        .miso_i      (miso_i),
        .mosi_o      (mosi_o),
        .byte_done_o (byte_done),
        .rx_byte_o   (rx_byte),
        .boundary_o  (boundary)
    );

    // byte that follows the one now on the wire
    always_comb begin
        cmd_shift = q.cmd << (BYTE_W * (int'(q.idx) + 1));
        next_byte = IDLE_BYTE;
        if (q.st == ST_CMD && q.idx != IDXW'(CMD_BYTES - 1))
            next_byte = cmd_shift[CMD_W-1 -: BYTE_W];
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        load   = 1'b0;
        if (boundary)
            d.cs_n = q.cs_pend;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    load      = 1'b1;
                    d.st      = ST_CMD;
                    d.idx     = '0;
                    d.cnt     = '0;
                    d.cmd     = cmd_i;
                    d.two     = resp_two_i;
                    d.btype   = busy_type_i;
                    d.cs_n    = 1'b0;
                    d.cs_pend = 1'b0;
                    d.run     = 1'b1;
                    d.ok      = 1'b0;
                    d.rto     = 1'b0;
                    d.bto     = 1'b0;
                    d.resp    = '0;
                end
            end
            ST_CMD: begin
                if (byte_done) begin
                    if (q.idx == IDXW'(CMD_BYTES - 1)) begin
                        d.st  = ST_WAIT;
                        d.cnt = '0;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (byte_done) begin
                    if (!rx_byte[BYTE_W-1]) begin
                        d.resp[BYTE_W-1:0] = rx_byte;
                        d.cnt = '0;
                        if (q.two)        d.st = ST_RESP2;
                        else if (q.btype) d.st = ST_BUSY;
                        else              d.st = ST_TRAIL;
                    end else if (q.cnt == CNTW'(RESP_WAIT - 1)) begin
                        d.rto = 1'b1;
                        d.cnt = '0;
                        d.st  = ST_TRAIL;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_RESP2: begin
                if (byte_done) begin
                    d.resp[RESP_W-1 -: BYTE_W] = rx_byte;
                    d.cnt = '0;
                    d.st  = q.btype ? ST_BUSY : ST_TRAIL;
                end
            end
            ST_BUSY: begin
                if (byte_done) begin
                    if (rx_byte == IDLE_BYTE) begin
                        d.cnt = '0;
                        d.st  = ST_TRAIL;
                    end else if (q.cnt == CNTW'(BUSY_MAX - 1)) begin
                        d.bto = 1'b1;
                        d.cnt = '0;
                        d.st  = ST_TRAIL;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                        if (RELEASE_CS != 0) begin
                            d.cs_pend = 1'b1;
                            d.st      = ST_DESEL;
                        end
                    end
                end
            end
            ST_DESEL: begin
                if (byte_done) begin
                    d.cs_pend = 1'b0;
                    d.st      = ST_BUSY;
                end
            end
            ST_TRAIL: begin
                if (byte_done) begin
                    if (q.cnt == CNTW'(TRAIL_BYTES - 1)) d.st = ST_END;
                    else                                 d.cnt = q.cnt + 1'b1;
                end
            end
            ST_END: begin
                if (boundary) begin
                    d.cs_n = 1'b1;
                    d.run  = 1'b0;
                    d.done = 1'b1;
                    d.ok   = !q.rto && !q.bto;
                    d.st   = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign busy_o     = (q.st != ST_IDLE);
    assign done_o     = q.done;
    assign ok_o       = q.ok;
    assign resp_tmo_o = q.rto;
    assign busy_tmo_o = q.bto;
    assign resp_o     = q.resp;
    assign cs_n_o     = q.cs_n;

    a_r11_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (cs_n_o && !sclk_o));
    a_r9_mosi_high_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> mosi_o);
    a_r2_cs_moves_sclk_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cs_n_o) |-> !sclk_o);
    a_r7_cs_high_only_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && cs_n_o) |-> (q.st == ST_DESEL || q.st == ST_BUSY));
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r10_one_status: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($countones({ok_o, resp_tmo_o, busy_tmo_o}) == 1));
    a_r3_timeout_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && resp_tmo_o) |-> (resp_o == '0));
    a_r6_busy_tmo_needs_type: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && busy_tmo_o) |-> q.btype);
endmodule

// File: tb/tb_spi_card_cmd_host.sv
`timescale 1ns/1ps

module tb_card (
    input  logic        clr,
    input  logic        sclk,
    input  logic        cs_n,
    input  logic        mosi,
    input  int          gap,
    input  int          rlen,
    input  int          busy_bytes,
    input  logic [7:0]  r1,
    input  logic [7:0]  r2,
    output logic        miso,
    output int          rises,
    output int          cs_hi_rises,
    output int          mosi_zeros,
    output logic [47:0] cmd_cap
);
    function automatic logic bitval(int i);
        int j, k, m;
        logic [7:0] by;
        if (i < 48) return 1'b1;
        j = i - 48;
        if (j < 8 * gap) return 1'b1;
        k = j - 8 * gap;
        if (k < 8 * rlen) begin
            by = (k < 8) ? r1 : r2;
            return by[7 - (k % 8)];
        end
        m = k - 8 * rlen;
        if (m < 8 * busy_bytes) return 1'b0;
        return 1'b1;
    endfunction

    assign miso = cs_n ? 1'b1 : bitval(rises);

    always @(posedge sclk or posedge clr) begin
        if (clr) begin
            rises       <= 0;
            cs_hi_rises <= 0;
            mosi_zeros  <= 0;
            cmd_cap     <= '0;
        end else begin
            if (rises < 48) cmd_cap <= {cmd_cap[46:0], mosi};
            else if (!mosi) mosi_zeros <= mosi_zeros + 1;
            if (cs_n) cs_hi_rises <= cs_hi_rises + 1;
            rises <= rises + 1;
        end
    end
endmodule

module tb_mon (
    input  logic clk,
    input  logic clr,
    input  logic sclk,
    input  logic mosi,
    input  logic cs_n,
    input  logic done,
    output int   done_cnt,
    output int   done_max,
    output int   mosi_bad
);
    int   run_len = 0;
    logic pm = 1'b1;
    logic ps = 1'b0;
    logic pcs = 1'b1;

    initial mosi_bad = 0;

    always @(negedge clk) begin
        if (clr) begin
            done_cnt = 0;
            done_max = 0;
            run_len  = 0;
        end else begin
            if (done) begin
                run_len = run_len + 1;
                if (run_len == 1) done_cnt = done_cnt + 1;
                if (run_len > done_max) done_max = run_len;
            end else begin
                run_len = 0;
            end
        end
        if ((mosi !== pm) && !(ps && !sclk) && !pcs) mosi_bad = mosi_bad + 1;
        pm  = mosi;
        ps  = sclk;
        pcs = cs_n;
    end
endmodule

module tb_spi_card_cmd_host;
    localparam int HD = 2;
    localparam int RW = 8;
    localparam int BM = 4;
    localparam int TB = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [47:0] cmd = '0;
    logic        two = 1'b0;
    logic        btype = 1'b0;
    logic        clr = 1'b0;

    int          c_gap = 0, c_rlen = 1, c_busy = 0;
    logic [7:0]  c_r1 = 8'h00, c_r2 = 8'h00;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    // two instances: [0] keeps cs low during busy, [1] releases it between polls
    logic        busy_v[2], done_v[2], ok_v[2], rto_v[2], bto_v[2];
    logic        sclk_v[2], mosi_v[2], cs_v[2], miso_v[2];
    logic [15:0] resp_v[2];
    int          rises_v[2], cshi_v[2], mz_v[2], dcnt_v[2], dmax_v[2], mbad_v[2];
    logic [47:0] cap_v[2];

    spi_card_cmd_host #(
        .HALF_DIV(HD), .CMD_BYTES(6), .RESP_WAIT(RW), .BUSY_MAX(BM),
        .TRAIL_BYTES(TB), .RELEASE_CS(0)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .cmd_i(cmd),
        .resp_two_i(two), .busy_type_i(btype), .busy_o(busy_v[0]),
        .done_o(done_v[0]), .ok_o(ok_v[0]), .resp_tmo_o(rto_v[0]),
        .busy_tmo_o(bto_v[0]), .resp_o(resp_v[0]), .sclk_o(sclk_v[0]),
        .mosi_o(mosi_v[0]), .cs_n_o(cs_v[0]), .miso_i(miso_v[0])
    );

    spi_card_cmd_host #(
        .HALF_DIV(HD), .CMD_BYTES(6), .RESP_WAIT(RW), .BUSY_MAX(BM),
        .TRAIL_BYTES(TB), .RELEASE_CS(1)
    ) dut_rel (
        .clk(clk), .rst_n(rst_n), .start_i(start), .cmd_i(cmd),
        .resp_two_i(two), .busy_type_i(btype), .busy_o(busy_v[1]),
        .done_o(done_v[1]), .ok_o(ok_v[1]), .resp_tmo_o(rto_v[1]),
        .busy_tmo_o(bto_v[1]), .resp_o(resp_v[1]), .sclk_o(sclk_v[1]),
        .mosi_o(mosi_v[1]), .cs_n_o(cs_v[1]), .miso_i(miso_v[1])
    );

    for (genvar g = 0; g < 2; g++) begin : g_side
        tb_card u_card (
            .clr(clr), .sclk(sclk_v[g]), .cs_n(cs_v[g]), .mosi(mosi_v[g]),
            .gap(c_gap), .rlen(c_rlen), .busy_bytes(c_busy), .r1(c_r1), .r2(c_r2),
            .miso(miso_v[g]), .rises(rises_v[g]), .cs_hi_rises(cshi_v[g]),
            .mosi_zeros(mz_v[g]), .cmd_cap(cap_v[g])
        );
        tb_mon u_mon (
            .clk(clk), .clr(clr), .sclk(sclk_v[g]), .mosi(mosi_v[g]),
            .cs_n(cs_v[g]), .done(done_v[g]), .done_cnt(dcnt_v[g]),
            .done_max(dmax_v[g]), .mosi_bad(mbad_v[g])
        );
    end

    task automatic chk(input bit good, input string req, input string what,
                       input longint act, input longint expv);
        n_chk++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 195000, 0);
        summary();
        $finish;
    end

    // expected edges, deselected edges and status (0 ok, 1 reply timeout, 2 busy timeout)
    task automatic expect_for(input int g, input int l, input int b, input bit bt,
                              input int rel, output int ex_r, output int ex_cs,
                              output int ex_st);
        int base, p, slots;
        ex_cs = 0;
        ex_st = 0;
        if (g >= RW) begin
            ex_r  = 48 + 8 * RW + 8 * TB;
            ex_st = 1;
            return;
        end
        base = 48 + 8 * (g + 1) + 8 * (l - 1);
        if (!bt) begin
            ex_r = base + 8 * TB;
            return;
        end
        p = (rel != 0) ? ((b + 1) / 2 + 1) : (b + 1);
        if (p > BM) begin
            p = BM;
            ex_st = 2;
        end
        slots = (rel != 0) ? (2 * p - 1) : p;
        if (rel != 0) ex_cs = 8 * (p - 1);
        ex_r = base + 8 * slots + 8 * TB;
    endtask

    task automatic run_txn(input int g, input int l, input int b, input bit bt,
                           input logic [7:0] r1v, input logic [7:0] r2v,
                           input logic [47:0] c, input bit restart, input string stag);
        int wait_cnt, ex_r, ex_cs, ex_st, st;
        logic [15:0] ex_resp;
        c_gap = g; c_rlen = l; c_busy = b; c_r1 = r1v; c_r2 = r2v;
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        cmd = c; two = (l == 2); btype = bt;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cmd = ~c;
        two = ~two;
        btype = ~bt;
        if (restart) begin
            repeat (100) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_cnt = 0;
        while (!(dcnt_v[0] >= 1 && dcnt_v[1] >= 1) && wait_cnt < 20000) begin
            @(negedge clk);
            wait_cnt++;
        end
        repeat (4) @(negedge clk);
        for (int s = 0; s < 2; s++) begin
            expect_for(g, l, b, bt, s, ex_r, ex_cs, ex_st);
            ex_resp = (ex_st == 1) ? 16'h0000 : {(l == 2) ? r2v : 8'h00, r1v};
            st = ok_v[s] ? 0 : (rto_v[s] ? 1 : (bto_v[s] ? 2 : 3));
            chk(cap_v[s] == c, "R1", "command bits at card", cap_v[s], c);
            chk(rises_v[s] == ex_r, stag, "sclk rising edges (R8 trailing)", rises_v[s], ex_r);
            chk(cshi_v[s] == ex_cs, "R7", "edges with cs_n high", cshi_v[s], ex_cs);
            chk(st == ex_st, (ex_st == 2) ? "R6" : "R3", "status code", st, ex_st);
            chk(resp_v[s] == ex_resp, "R4", "captured reply", resp_v[s], ex_resp);
            chk(mz_v[s] == 0, "R9", "mosi zero bits after command", mz_v[s], 0);
            chk(dcnt_v[s] == 1 && dmax_v[s] == 1, "R10", "done pulses x10 + width",
                dcnt_v[s] * 10 + dmax_v[s], 11);
            chk(cs_v[s] && !sclk_v[s] && !busy_v[s], "R8", "cs_n,sclk,busy after end",
                {cs_v[s], sclk_v[s], busy_v[s]}, 3'b100);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset levels
        for (int s = 0; s < 2; s++)
            chk(cs_v[s] && !sclk_v[s] && mosi_v[s] && !busy_v[s] && !done_v[s], "R11",
                "cs_n,sclk,mosi,busy,done in reset",
                {cs_v[s], sclk_v[s], mosi_v[s], busy_v[s], done_v[s]}, 5'b10100);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        for (int s = 0; s < 2; s++)
            chk(cs_v[s] && !sclk_v[s] && mosi_v[s] && !busy_v[s] && !done_v[s], "R11",
                "idle levels after reset",
                {cs_v[s], sclk_v[s], mosi_v[s], busy_v[s], done_v[s]}, 5'b10100);

        // R3/R4: reply gap swept through and past the poll limit, both reply lengths
        for (int l = 1; l <= 2; l++)
            for (int g = 0; g <= RW + 1; g++)
                run_txn(g, l, 0, 1'b0, 8'(g * 13 + l) & 8'h7F, 8'hA5 ^ 8'(g),
                        {8'h40 | 8'(g + l), 32'h1234_5678 ^ 32'(g * 977), 8'h95},
                        1'b0, "R3");

        // R5/R6/R7: busy length swept through and past the poll limit
        for (int b = 0; b <= 9; b++)
            run_txn(1, 1, b, 1'b1, 8'h00, 8'h00,
                    {8'h4C, 32'hC0DE_0000 | 32'(b), 8'h01}, 1'b0, "R5");
        run_txn(2, 2, 3, 1'b1, 8'h04, 8'h3C, 48'h4D_0000_0000_FF, 1'b0, "R4");

        // R5: busy level on miso without the busy flag has no effect
        run_txn(3, 1, 6, 1'b0, 8'h01, 8'h00, 48'h58_0001_0200_AB, 1'b0, "R5");

        // R1: start during an active transaction is ignored
        run_txn(4, 1, 0, 1'b0, 8'h05, 8'h00, 48'h51_8000_0001_0F, 1'b1, "R1");

        // R2: mosi only moved on falling sclk edges or at a start
        for (int s = 0; s < 2; s++)
            chk(mbad_v[s] == 0, "R2", "mosi changes outside falling edges", mbad_v[s], 0);

        summary();
        $finish;
    end
endmodule